// File: doc/BRIEF.md
# Dual-Half Shadow-Banked Register File

This block is a sixteen-entry data register file for a processing core that needs fast context switches. Every entry exists twice: a primary copy and an alternate (shadow) copy. The file is cut into a lower half (indices 0 to 7) and an upper half (indices 8 to 15). Each half has its own select bit, so software can swap one half into its alternate set while the other half stays where it is. A context switch then costs one control write instead of a save and restore of every register.

The file has two combinational read ports and one write port. It also has a write port for the two-bit bank-select register. Reads and writes only reach the set that is currently selected for the half being addressed. The other set keeps its contents untouched until it is selected again.

To share values between two contexts, a program leaves them in one half and flips only the other half's select bit. A select write is registered. Accesses issued in the same cycle still see the old selection, and the new selection applies from the next cycle onward.

Top module: `rf_banked`

## Requirements
- R1: A 4-bit register index addresses 16 registers. Index bit 3 picks the half (0 = lower, 1 = upper) and bits 2:0 pick the entry within that half.
- R2: Bank-select bit 0 governs the lower half and bit 1 governs the upper half. In each bit, 0 selects the primary set and 1 selects the alternate set.
- R3: A bank-select write updates the selection at the clock edge that ends its cycle. Reads and writes issued in the same cycle as the select write use the previous selection.
- R4: A data write changes only the addressed entry of the currently selected set of the addressed half. The unselected set keeps its contents, and so does every other entry.
- R5: Switching one half's set does not alter which data the other half presents, so values left in the unswitched half stay visible across a context switch.
- R6: Reset (active-low `rst_n`) selects the primary set in both halves and clears all 32 physical registers to zero.
- R7: The two read ports return the current contents of their own indices independently and combinationally, in the same cycle the index is presented.
- R8: A read of the entry being written in the same cycle returns the value held before the write. The new value appears from the next cycle.
- R9: `bank_sel` presents the registered bank-select value, and it holds steady in cycles without a select write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data write enable |
| wr_addr | input | 4 | Data write index |
| wr_data | input | DATA_W | Data write value |
| rd_a_addr | input | 4 | Read port A index |
| rd_a_data | output | DATA_W | Read port A value |
| rd_b_addr | input | 4 | Read port B index |
| rd_b_data | output | DATA_W | Read port B value |
| sel_wr_en | input | 1 | Bank-select write enable |
| sel_wr_data | input | 2 | New bank-select value (bit 0 lower, bit 1 upper) |
| bank_sel | output | 2 | Current bank-select value |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and sixteen logical entries. At these values every one of the 32 physical registers, and all four combinations of the two select bits, can be reached through the ports. The stimulus table uses distinct values in the same index under each set. This separates a write that landed in the wrong set or the wrong half from a correct one. It also pairs each select write with a same-cycle access, so the old-selection rule is observed directly.

// File: rtl/rf_banked_pkg.sv
package rf_banked_pkg;
    localparam int unsigned HALVES = 2;
    localparam int unsigned SETS   = 2;

    typedef enum logic {
        SET_PRIMARY   = 1'b0,
        SET_ALTERNATE = 1'b1
    } set_sel_e;
endpackage

// File: rtl/rf_mode_ctrl.sv
module rf_mode_ctrl #(
    parameter int unsigned HALVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALVES-1:0] wr_data,
    output logic [HALVES-1:0] sel_q
);
    typedef struct packed {
        logic [HALVES-1:0] sel;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;
endmodule

// File: rtl/rf_half_bank.sv
module rf_half_bank
    import rf_banked_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  set_sel_e          set_sel,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data
);
    typedef struct packed {
        logic [SETS-1:0][DEPTH-1:0][DATA_W-1:0] store;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.store[set_sel][wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_data = st_q.store[set_sel][rd_a_idx];
    assign rd_b_data = st_q.store[set_sel][rd_b_idx];
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALVES = 2,
    localparam int unsigned HS_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic [HALVES-1:0][DATA_W-1:0] half_data,
    input  logic [HS_W-1:0]               half_idx,
    output logic [DATA_W-1:0]             data_out
);
    always_comb begin
        data_out = '0;
        for (int h = 0; h < HALVES; h++) begin
            if (half_idx == HS_W'(h)) begin
                data_out = half_data[h];
            end
        end
    end
endmodule

// File: rtl/rf_banked.sv
module rf_banked
    import rf_banked_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_a_addr,
    output logic [DATA_W-1:0]           rd_a_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_b_addr,
    output logic [DATA_W-1:0]           rd_b_data,
    input  logic                        sel_wr_en,
    input  logic [HALVES-1:0]           sel_wr_data,
    output logic [HALVES-1:0]           bank_sel
);
    localparam int unsigned ADDR_W     = $clog2(NUM_REGS);
    localparam int unsigned HALF_DEPTH = NUM_REGS / HALVES;
    localparam int unsigned IDX_W      = $clog2(HALF_DEPTH);
    localparam int unsigned HS_W       = ADDR_W - IDX_W;

    logic [HALVES-1:0]             sel_q;
    logic [HALVES-1:0][DATA_W-1:0] half_rd_a;
    logic [HALVES-1:0][DATA_W-1:0] half_rd_b;

    rf_mode_ctrl #(
        .HALVES (HALVES)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .sel_q   (sel_q)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic     hit_wr;
        set_sel_e set_now;

        assign hit_wr  = wr_en && (wr_addr[ADDR_W-1:IDX_W] == HS_W'(h));
        assign set_now = set_sel_e'(sel_q[h]);

        rf_half_bank #(
            .DATA_W (DATA_W),
            .DEPTH  (HALF_DEPTH)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_sel   (set_now),
            .wr_en     (hit_wr),
            .wr_idx    (wr_addr[IDX_W-1:0]),
            .wr_data   (wr_data),
            .rd_a_idx  (rd_a_addr[IDX_W-1:0]),
            .rd_b_idx  (rd_b_addr[IDX_W-1:0]),
            .rd_a_data (half_rd_a[h]),
            .rd_b_data (half_rd_b[h])
        );
    end

    rf_read_sel #(
        .DATA_W (DATA_W),
        .HALVES (HALVES)
    ) u_sel_a (
        .half_data (half_rd_a),
        .half_idx  (rd_a_addr[ADDR_W-1:IDX_W]),
        .data_out  (rd_a_data)
    );

    rf_read_sel #(
        .DATA_W (DATA_W),
        .HALVES (HALVES)
    ) u_sel_b (
        .half_data (half_rd_b),
        .half_idx  (rd_b_addr[ADDR_W-1:IDX_W]),
        .data_out  (rd_b_data)
    );

    assign bank_sel = sel_q;
endmodule

// File: rtl/rf_banked_chk.sv
module rf_banked_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned HALVES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              sel_wr_en,
    input logic [HALVES-1:0] sel_wr_data,
    input logic [HALVES-1:0] bank_sel
);
    // Select write is visible exactly one cycle later.
    assert_sel_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> (bank_sel == $past(sel_wr_data)));

    // Without a select write the selection holds.
    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr_en |=> $stable(bank_sel));

    // A data write with no concurrent select change is read back on port A next cycle.
    assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_wr_en) |=>
            ((rd_a_addr != $past(wr_addr)) || (rd_a_data == $past(wr_data))));

    // With no write of any kind, a held index reads a held value.
    assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !sel_wr_en) |=>
            ((rd_b_addr != $past(rd_b_addr)) || $stable(rd_b_data)));
endmodule

bind rf_banked rf_banked_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .HALVES (HALVES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_a_addr   (rd_a_addr),
    .rd_a_data   (rd_a_data),
    .rd_b_addr   (rd_b_addr),
    .rd_b_data   (rd_b_data),
    .sel_wr_en   (sel_wr_en),
    .sel_wr_data (sel_wr_data),
    .bank_sel    (bank_sel)
);

// File: tb/rf_banked_bench.sv
`timescale 1ns/1ps
module rf_banked_bench;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0]    rd_a_addr = '0;
    logic [DW-1:0] rd_a_data;
    logic [3:0]    rd_b_addr = '0;
    logic [DW-1:0] rd_b_data;
    logic          sel_wr_en = 1'b0;
    logic [1:0]    sel_wr_data = '0;
    logic [1:0]    bank_sel;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rf_banked u_rf_banked (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_a_addr   (rd_a_addr),
        .rd_a_data   (rd_a_data),
        .rd_b_addr   (rd_b_addr),
        .rd_b_data   (rd_b_data),
        .sel_wr_en   (sel_wr_en),
        .sel_wr_data (sel_wr_data),
        .bank_sel    (bank_sel)
    );

    // fields: select write, select value, data write, write index, write data,
    // read index (port A), expected port A value in the same cycle
    typedef struct packed {
        logic       sw;
        logic [1:0] sv;
        logic       we;
        logic [3:0] wa;
        logic [31:0] wd;
        logic [3:0] ra;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 1'b1, 4'd3,  32'hA003, 4'd3,  32'h0},     // R8 old value on same-cycle write
        '{1'b0, 2'd0, 1'b1, 4'd11, 32'hB011, 4'd3,  32'hA003},  // R1
        '{1'b1, 2'd1, 1'b1, 4'd3,  32'hC003, 4'd3,  32'hA003},  // R3 write uses old (primary) set
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd3,  32'h0},     // R2 lower alternate empty
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd11, 32'hB011},  // R5 upper untouched
        '{1'b0, 2'd0, 1'b1, 4'd3,  32'hD003, 4'd11, 32'hB011},  // R5
        '{1'b1, 2'd0, 1'b0, 4'd0,  32'h0,    4'd3,  32'hD003},  // R3 read uses old (alternate) set
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd3,  32'hC003},  // R4 primary preserved
        '{1'b1, 2'd2, 1'b1, 4'd11, 32'hE011, 4'd3,  32'hC003},  // R3
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd11, 32'h0},     // R2 upper alternate empty
        '{1'b0, 2'd0, 1'b1, 4'd11, 32'hF011, 4'd3,  32'hC003},  // R5
        '{1'b1, 2'd3, 1'b0, 4'd0,  32'h0,    4'd11, 32'hF011},  // R4
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd3,  32'hD003},  // R2 both alternate
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd11, 32'hF011},  // R2
        '{1'b1, 2'd0, 1'b0, 4'd0,  32'h0,    4'd11, 32'hF011},  // R3
        '{1'b0, 2'd0, 1'b0, 4'd0,  32'h0,    4'd11, 32'hE011}   // R4 upper primary preserved
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0;
        sel_wr_en = 1'b0;
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset state, primary and alternate empty
        @(negedge clk);
        #1;
        check("R6 bank_sel after reset", DW'(bank_sel), '0);
        for (int i = 0; i < 16; i++) begin
            rd_a_addr = 4'(i);
            rd_b_addr = 4'(15 - i);
            #1;
            check("R6 port A zero after reset", rd_a_data, '0);
            check("R6 port B zero after reset", rd_b_data, '0);
        end

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            sel_wr_en   = VEC[v].sw;
            sel_wr_data = VEC[v].sv;
            wr_en       = VEC[v].we;
            wr_addr     = VEC[v].wa;
            wr_data     = VEC[v].wd;
            rd_a_addr   = VEC[v].ra;
            #1;
            check($sformatf("R2/R3/R4/R5/R8 vector %0d", v), rd_a_data, VEC[v].ex);
        end
        @(negedge clk);
        idle();

        // R9: select output and hold
        @(negedge clk);
        sel_wr_en = 1'b1;
        sel_wr_data = 2'b10;
        #1;
        check("R9 bank_sel before edge", DW'(bank_sel), 32'd0);
        @(negedge clk);
        idle();
        #1;
        check("R9 bank_sel after write", DW'(bank_sel), 32'd2);
        @(negedge clk);
        #1;
        check("R9 bank_sel held", DW'(bank_sel), 32'd2);

        // R7: two ports, different halves, same cycle
        rd_a_addr = 4'd3;
        rd_b_addr = 4'd11;
        #1;
        check("R7 port A lower primary", rd_a_data, 32'hC003);
        check("R7 port B upper alternate", rd_b_data, 32'hF011);

        // R1: entry 7 vs entry 15 are distinct registers
        @(negedge clk);
        sel_wr_en = 1'b1;
        sel_wr_data = 2'b00;
        @(negedge clk);
        idle();
        wr_en = 1'b1;
        wr_addr = 4'd7;
        wr_data = 32'h7777;
        @(negedge clk);
        wr_addr = 4'd15;
        wr_data = 32'hFFFF;
        @(negedge clk);
        idle();
        rd_a_addr = 4'd7;
        rd_b_addr = 4'd15;
        #1;
        check("R1 index 7", rd_a_data, 32'h7777);
        check("R1 index 15", rd_b_data, 32'hFFFF);

        // R8 on port B too
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 4'd15;
        wr_data = 32'h1234;
        #1;
        check("R8 port B same-cycle old", rd_b_data, 32'hFFFF);
        @(negedge clk);
        idle();
        #1;
        check("R8 port B new value next cycle", rd_b_data, 32'h1234);

        // R6: reset mid-run clears storage and selection
        @(negedge clk);
        sel_wr_en = 1'b1;
        sel_wr_data = 2'b11;
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R6 bank_sel cleared", DW'(bank_sel), '0);
        rd_a_addr = 4'd3;
        rd_b_addr = 4'd15;
        #1;
        check("R6 entry 3 cleared", rd_a_data, '0);
        check("R6 entry 15 cleared", rd_b_data, '0);
        @(negedge clk);
        sel_wr_en = 1'b1;
        sel_wr_data = 2'b11;
        @(negedge clk);
        idle();
        rd_a_addr = 4'd3;
        rd_b_addr = 4'd11;
        #1;
        check("R6 lower alternate cleared", rd_a_data, '0);
        check("R6 upper alternate cleared", rd_b_data, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule